// File: doc/BRIEF.md
# Flash command interpreter and read-mode selector

This block is the command front end of a byte-wide flash memory model built from equal 64-Kbyte erase blocks. It watches bus write cycles. When write enable rises while chip enable is low, it takes the data byte as a command. Single-cycle commands select what later reads return: the memory array, an identifier table or the status byte. The choice holds until another valid command arrives. The read data output is steered to match that choice.

A two-cycle erase sequence is handed to a separate erase sequencer. It is a setup byte followed by a confirm byte, and the address of the confirm byte picks the block. The handoff is a one-cycle start pulse plus a block index, and the sequencer answers with busy and suspended flags. While the sequencer runs and is not suspended, most commands are refused. Power-up and deep power-down both return the block to array reads. One parameter selects the density, which sets the address width, the block count and the device code.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset, rd_mode is 0 (array) and rd_data equals arr_rdata; seq_start is low.
- R2: While pwrdn_n is low, rd_data reads 0x00 and bus commands are ignored. Once pwrdn_n returns high, the mode is array (rd_mode 0).
- R3: A command byte is taken only on a clock edge where bus_we_n is seen rising (low at the previous edge, high now) with bus_ce_n low. A write cycle with bus_ce_n high changes nothing.
- R4: Byte 0xFF selects array (rd_mode 0), 0x90 selects identifier (rd_mode 1) and 0x70 selects status (rd_mode 2, rd_data = stat_byte). The mode persists across any number of reads. Unrecognised bytes leave the mode unchanged.
- R5: While seq_busy is high and seq_susp is low, 0xFF and 0x90 are ignored and 0x70 is still accepted. Byte 0x20 is ignored whenever seq_busy is high. With seq_susp high, 0xFF is accepted.
- R6: In identifier mode, address 0x000000 reads 0x89.
- R7: In identifier mode, address 0x000001 reads the device code: 0xA7 for 4 Mbit, 0xA6 for 8 Mbit and 0xAA for 16 Mbit.
- R8: In identifier mode, an address whose low 16 bits are 0x0002 reads {7'b0, blk_lock[b]}. Here b is the block number held in the address bits above bit 15.
- R9: In identifier mode, address 0x000003 reads {7'b0, master_lock}. Every other identifier address reads 0x00.
- R10: Byte 0x20 followed by byte 0xD0, with seq_busy low, gives a seq_start pulse of exactly one cycle in the cycle after the confirm is taken. seq_blk then holds the block number of the confirm address, and the mode becomes status.
- R11: Byte 0x20 followed by any byte other than 0xD0 gives no seq_start. The mode becomes status, and the second byte is not executed as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| pwrdn_n | input | 1 | Low holds the device in deep power-down |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low; command taken on its rise |
| bus_addr | input | AW | Byte address (AW = 16 + log2 of block count) |
| bus_wdata | input | 8 | Command byte on the data bus |
| arr_rdata | input | 8 | Byte read from the array at bus_addr |
| stat_byte | input | 8 | Current status register byte |
| blk_lock | input | NBLK | Lock bit per block, 1 = locked |
| master_lock | input | 1 | Device-wide lock bit, 1 = locked |
| seq_busy | input | 1 | Erase sequencer is running |
| seq_susp | input | 1 | Running operation is suspended |
| seq_start | output | 1 | One-cycle erase start pulse |
| seq_blk | output | BW | Block number to erase, valid with seq_start |
| rd_mode | output | 2 | Current read source: 0 array, 1 identifier, 2 status |
| rd_data | output | 8 | Byte presented on reads |

## Verification
The bench builds the block at 8 Mbit. That density gives 16 blocks, a 20-bit address and device code 0xA6. It can then read lock bits from the lowest block, the highest block and a middle block under a mixed lock pattern. It can also start an erase on a block whose index needs all four block bits. Identifier addresses that match only in the low 16 bits, or only in the upper bits, are used to show that the fixed codes decode on the full address and the lock read decodes on the block offset.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [1:0] {
      RM_ARRAY  = 2'd0,
      RM_IDENT  = 2'd1,
      RM_STATUS = 2'd2
   } rmode_t;

   typedef enum logic [2:0] {
      CK_NONE,
      CK_ARRAY,
      CK_IDENT,
      CK_STATUS,
      CK_ERASE_SETUP,
      CK_CONFIRM
   } cmd_kind_t;

   localparam logic [7:0] OP_ARRAY   = 8'hFF;
   localparam logic [7:0] OP_IDENT   = 8'h90;
   localparam logic [7:0] OP_STATUS  = 8'h70;
   localparam logic [7:0] OP_ESETUP  = 8'h20;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] MFR_CODE   = 8'h89;

   localparam int BLK_OFS_BITS = 16;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
   import flash_cmd_pkg::*;
(
   input  logic [7:0] code,
   output cmd_kind_t  kind
);

   always_comb begin
      case (code)
         OP_ARRAY:   kind = CK_ARRAY;
         OP_IDENT:   kind = CK_IDENT;
         OP_STATUS:  kind = CK_STATUS;
         OP_ESETUP:  kind = CK_ERASE_SETUP;
         OP_CONFIRM: kind = CK_CONFIRM;
         default:    kind = CK_NONE;
      endcase
   end

endmodule

// File: rtl/flash_bus_strobe.sv
module flash_bus_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic we_n,
   output logic strobe
);

   logic we_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_q <= 1'b1;
      else        we_q <= we_n;
   end

   assign strobe = !we_q && we_n && !ce_n;

endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int BW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwrdn_n,
   input  logic          strobe,
   input  cmd_kind_t     kind,
   input  logic [BW-1:0] blk,
   input  logic          seq_busy,
   input  logic          seq_susp,
   output rmode_t        mode,
   output logic          seq_start,
   output logic [BW-1:0] seq_blk
);

   logic erase_armed;
   logic lockout;

   assign lockout = seq_busy && !seq_susp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode        <= RM_ARRAY;
         erase_armed <= 1'b0;
         seq_start   <= 1'b0;
         seq_blk     <= '0;
      end else if (!pwrdn_n) begin
         mode        <= RM_ARRAY;
         erase_armed <= 1'b0;
         seq_start   <= 1'b0;
      end else begin
         seq_start <= 1'b0;
         if (strobe) begin
            if (erase_armed) begin
               erase_armed <= 1'b0;
               mode        <= RM_STATUS;
               if (kind == CK_CONFIRM && !seq_busy) begin
                  seq_start <= 1'b1;
                  seq_blk   <= blk;
               end
            end else begin
               case (kind)
                  CK_ARRAY:  if (!lockout) mode <= RM_ARRAY;
                  CK_IDENT:  if (!lockout) mode <= RM_IDENT;
                  CK_STATUS: mode <= RM_STATUS;
                  CK_ERASE_SETUP:
                     if (!seq_busy) begin
                        erase_armed <= 1'b1;
                        mode        <= RM_STATUS;
                     end
                  default: ;
               endcase
            end
         end
      end
   end

   p_pdn_default_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwrdn_n |=> (mode == RM_ARRAY));

   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwrdn_n && !strobe) |=> $stable(mode));

   p_mode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd3);

   p_busy_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pwrdn_n && strobe && !erase_armed && lockout && kind == CK_ARRAY)
      |=> (mode == $past(mode)));

   p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |=> !seq_start);

   p_start_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |-> ($past(strobe) && $past(pwrdn_n) && !$past(seq_busy)));

endmodule

// File: rtl/flash_id_table.sv
module flash_id_table
   import flash_cmd_pkg::*;
#(
   parameter int MBIT = 16,
   parameter int NBLK = 32,
   parameter int BW   = 5,
   parameter int AW   = 21
) (
   input  logic [AW-1:0]   addr,
   input  logic [NBLK-1:0] blk_lock,
   input  logic            master_lock,
   output logic [7:0]      id_byte
);

   logic [7:0]                dev_code;
   logic [BLK_OFS_BITS-1:0]   ofs;
   logic [BW-1:0]             blk;

   generate
      if (MBIT == 4) begin : g_d4
         assign dev_code = 8'hA7;
      end else if (MBIT == 8) begin : g_d8
         assign dev_code = 8'hA6;
      end else if (MBIT == 16) begin : g_d16
         assign dev_code = 8'hAA;
      end else begin : g_bad
         $error("flash_id_table: MBIT must be 4, 8 or 16");
         assign dev_code = 8'h00;
      end
   endgenerate

   assign ofs = addr[BLK_OFS_BITS-1:0];
   assign blk = addr[AW-1:BLK_OFS_BITS];

   always_comb begin
      id_byte = 8'h00;
      if (ofs == 16'h0002) begin
         id_byte = {7'b0, blk_lock[blk]};
      end else if (blk == '0) begin
         case (ofs)
            16'h0000: id_byte = MFR_CODE;
            16'h0001: id_byte = dev_code;
            16'h0003: id_byte = {7'b0, master_lock};
            default:  id_byte = 8'h00;
         endcase
      end
   end

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
   import flash_cmd_pkg::*;
#(
   parameter  int MBIT = 16,
   localparam int NBLK = MBIT * 2,
   localparam int BW   = $clog2(NBLK),
   localparam int AW   = BLK_OFS_BITS + BW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pwrdn_n,
   input  logic            bus_ce_n,
   input  logic            bus_we_n,
   input  logic [AW-1:0]   bus_addr,
   input  logic [7:0]      bus_wdata,
   input  logic [7:0]      arr_rdata,
   input  logic [7:0]      stat_byte,
   input  logic [NBLK-1:0] blk_lock,
   input  logic            master_lock,
   input  logic            seq_busy,
   input  logic            seq_susp,
   output logic            seq_start,
   output logic [BW-1:0]   seq_blk,
   output logic [1:0]      rd_mode,
   output logic [7:0]      rd_data
);

   logic      strobe;
   cmd_kind_t kind;
   rmode_t    mode;
   logic [7:0] id_byte;

   flash_bus_strobe u_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce_n   (bus_ce_n),
      .we_n   (bus_we_n),
      .strobe (strobe)
   );

   flash_cmd_decode u_dec (
      .code (bus_wdata),
      .kind (kind)
   );

   flash_mode_ctrl #(.BW(BW)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwrdn_n   (pwrdn_n),
      .strobe    (strobe),
      .kind      (kind),
      .blk       (bus_addr[AW-1:BLK_OFS_BITS]),
      .seq_busy  (seq_busy),
      .seq_susp  (seq_susp),
      .mode      (mode),
      .seq_start (seq_start),
      .seq_blk   (seq_blk)
   );

   flash_id_table #(.MBIT(MBIT), .NBLK(NBLK), .BW(BW), .AW(AW)) u_id (
      .addr        (bus_addr),
      .blk_lock    (blk_lock),
      .master_lock (master_lock),
      .id_byte     (id_byte)
   );

   assign rd_mode = mode;

   always_comb begin
      if (!pwrdn_n) begin
         rd_data = 8'h00;
      end else begin
         case (mode)
            RM_IDENT:  rd_data = id_byte;
            RM_STATUS: rd_data = stat_byte;
            default:   rd_data = arr_rdata;
         endcase
      end
   end

   p_mfr_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwrdn_n && mode == RM_IDENT && bus_addr == '0) |-> (rd_data == MFR_CODE));

   p_pdn_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwrdn_n |-> (rd_data == 8'h00));

endmodule

// File: tb/flash_cmd_front_test.sv
module flash_cmd_front_test;

   localparam int MBIT = 8;
   localparam int NBLK = 16;
   localparam int BW   = 4;
   localparam int AW   = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            pwrdn_n = 1'b1;
   logic            bus_ce_n = 1'b1;
   logic            bus_we_n = 1'b1;
   logic [AW-1:0]   bus_addr = '0;
   logic [7:0]      bus_wdata = 8'h00;
   logic [7:0]      arr_rdata = 8'h5C;
   logic [7:0]      stat_byte = 8'h80;
   logic [NBLK-1:0] blk_lock = 16'hA5C3;
   logic            master_lock = 1'b1;
   logic            seq_busy = 1'b0;
   logic            seq_susp = 1'b0;
   logic            seq_start;
   logic [BW-1:0]   seq_blk;
   logic [1:0]      rd_mode;
   logic [7:0]      rd_data;

   int checks = 0;
   int fails  = 0;
   logic last_start;

   always #5 clk = ~clk;

   flash_cmd_front #(.MBIT(MBIT)) uut (
      .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
      .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .arr_rdata(arr_rdata), .stat_byte(stat_byte),
      .blk_lock(blk_lock), .master_lock(master_lock),
      .seq_busy(seq_busy), .seq_susp(seq_susp),
      .seq_start(seq_start), .seq_blk(seq_blk),
      .rd_mode(rd_mode), .rd_data(rd_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] d, input logic [AW-1:0] a, input logic ce);
      @(negedge clk);
      bus_ce_n  = ce;
      bus_we_n  = 1'b0;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_we_n = 1'b1;
      @(negedge clk);
      bus_ce_n   = 1'b1;
      last_start = seq_start;
   endtask

   task automatic cmd(input logic [7:0] d);
      bus_write(d, '0, 1'b0);
   endtask

   task automatic read_at(input logic [AW-1:0] a);
      @(negedge clk);
      bus_addr = a;
      #1;
   endtask

   task automatic t_reset;
      chk("R1 mode after reset", rd_mode, 2'd0);
      chk("R1 data after reset", rd_data, arr_rdata);
      chk("R1 start after reset", seq_start, 1'b0);
   endtask

   task automatic t_modes;
      cmd(8'h90);
      chk("R4 ident select", rd_mode, 2'd1);
      read_at(20'h0_0000);
      chk("R6 manufacturer", rd_data, 8'h89);
      read_at(20'h0_0001);
      read_at(20'h0_0000);
      chk("R4 ident persists", rd_data, 8'h89);
      cmd(8'h70);
      chk("R4 status select", rd_mode, 2'd2);
      chk("R4 status data", rd_data, stat_byte);
      cmd(8'h42);
      chk("R4 unknown ignored", rd_mode, 2'd2);
      cmd(8'hFF);
      chk("R4 array select", rd_mode, 2'd0);
      arr_rdata = 8'h3E;
      #1;
      chk("R4 array data", rd_data, 8'h3E);
   endtask

   task automatic t_ce_gate;
      bus_write(8'h90, '0, 1'b1);
      chk("R3 ce high ignored", rd_mode, 2'd0);
      bus_write(8'h70, '0, 1'b0);
      chk("R3 ce low taken", rd_mode, 2'd2);
   endtask

   task automatic t_ident;
      cmd(8'h90);
      read_at(20'h0_0001);
      chk("R7 device code", rd_data, 8'hA6);
      read_at(20'h0_0002);
      chk("R8 lock blk0", rd_data, 8'h01);
      read_at({4'd5, 16'h0002});
      chk("R8 lock blk5", rd_data, 8'h00);
      read_at({4'd15, 16'h0002});
      chk("R8 lock blk15", rd_data, 8'h01);
      read_at(20'h0_0003);
      chk("R9 master lock", rd_data, 8'h01);
      master_lock = 1'b0;
      #1;
      chk("R9 master unlocked", rd_data, 8'h00);
      read_at({4'd3, 16'h0000});
      chk("R9 upper block id addr", rd_data, 8'h00);
      read_at(20'h0_0005);
      chk("R9 other addr", rd_data, 8'h00);
   endtask

   task automatic t_busy;
      seq_busy = 1'b1;
      cmd(8'hFF);
      chk("R5 busy refuses array", rd_mode, 2'd1);
      cmd(8'h70);
      chk("R5 busy accepts status", rd_mode, 2'd2);
      cmd(8'h90);
      chk("R5 busy refuses ident", rd_mode, 2'd2);
      cmd(8'h20);
      bus_write(8'hD0, {4'd7, 16'h0000}, 1'b0);
      chk("R5 busy refuses erase", last_start, 1'b0);
      seq_susp = 1'b1;
      cmd(8'hFF);
      chk("R5 suspended accepts array", rd_mode, 2'd0);
      seq_busy = 1'b0;
      seq_susp = 1'b0;
   endtask

   task automatic t_erase;
      cmd(8'h20);
      chk("R10 setup no start", last_start, 1'b0);
      bus_write(8'hD0, {4'd9, 16'h1234}, 1'b0);
      chk("R10 start pulse", last_start, 1'b1);
      chk("R10 block index", seq_blk, 4'd9);
      chk("R10 status mode", rd_mode, 2'd2);
      @(negedge clk);
      chk("R10 pulse ends", seq_start, 1'b0);
   endtask

   task automatic t_cancel;
      cmd(8'hFF);
      cmd(8'h20);
      cmd(8'h90);
      chk("R11 no start", last_start, 1'b0);
      chk("R11 status not ident", rd_mode, 2'd2);
      cmd(8'h90);
      chk("R11 next cmd normal", rd_mode, 2'd1);
   endtask

   task automatic t_pdn;
      @(negedge clk);
      pwrdn_n = 1'b0;
      #1;
      chk("R2 data quiet", rd_data, 8'h00);
      cmd(8'h70);
      @(negedge clk);
      pwrdn_n = 1'b1;
      #1;
      chk("R2 array after exit", rd_mode, 2'd0);
      chk("R2 array data after exit", rd_data, arr_rdata);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_modes();
      t_ce_gate();
      t_ident();
      t_busy();
      t_erase();
      t_cancel();
      t_pdn();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule